// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

This block watches sixteen interrupt request flags and picks one of them to present to a CPU, together with the source number and a fixed vector address. Source 0 is the power-fail source. It sits alone on a reserved top level and is gated only by its own enable. Sources 1 to 15 need their own enable and the global enable. Each of them is placed on the high or low level by a priority bit. Within one level, the lower source number wins.

Vectors are fixed and not linear. Source 0 maps to 33h. Sources 1 to 6 map to 03h + 8·(n−1). Sources 7 to 15 map to 3Bh + 8·(n−7), so these skip over 33h. Sources 2, 13 and 15 each have a second flag input that also raises a request. Examples are a transmit flag beside a receive flag, or a second overflow flag.

A small state machine has two states, `ST_IDLE` and `ST_WAIT_ACK`. Transition IDLE→WAIT_ACK happens when an eligible candidate exists at a clock edge; the vector is latched on that edge. Transition WAIT_ACK→IDLE happens on `ack`. An in-service register holds one bit per level. On acknowledge, the bit for the winner's level is set. On `reti`, the highest set bit is cleared. A request is presented only if its level is strictly above every level in service. This is what makes nesting work. Clearing the flags is left to software.

Top module: `intc3_top`

## Requirements
- R1: While `rst_n` is low, `irq`, `vector` and `src_id` are 0 and no level is in service, whatever the request inputs are.
- R2: Source 0 requests on the top level (encoded 2) when `req_flag[0]` and `src_en[0]` are 1, regardless of `glob_en` and `src_hi[0]`.
- R3: A source n in 1..15 is considered only when `req_flag[n]` (or its second flag), `src_en[n]` and `glob_en` are all 1; with `glob_en` 0 none of them raise `irq`.
- R4: For sources 1..15, `src_hi[n]`=1 places the source on the high level (1) and 0 on the low level (0); a request on a higher level wins over any request on a lower level regardless of source number.
- R5: Among competing requests on the same level, the lowest source number wins.
- R6: `vector` equals 33h for source 0, 03h+8·(n−1) for n=1..6 and 3Bh+8·(n−7) for n=7..15, and `src_id` equals the winner n.
- R7: `req_alt[n]` raises a request exactly as `req_flag[n]` does for n = 2, 13, 15 and is ignored for every other source.
- R8: From idle, `irq` rises on the cycle after a clock edge at which an eligible request exists; while `irq` is high and `ack` is low, `irq`, `vector` and `src_id` stay unchanged even if the requests change.
- R9: When `ack` is sampled high with `irq` high, `irq` falls on the next cycle and the winner's level becomes in service; `ack` sampled while `irq` is low has no effect.
- R10: A request is presented only if its level is strictly higher than the highest level in service; same-level or lower-level requests wait.
- R11: `reti` removes only the highest in-service level; lower in-service levels stay, and `reti` with nothing in service has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_flag | input | 16 | Main request flag per source, bit n = source n |
| req_alt | input | 16 | Second request flag, used by sources 2, 13, 15 only |
| src_en | input | 16 | Per-source enable |
| glob_en | input | 1 | Global enable for sources 1..15 |
| src_hi | input | 16 | Per-source high-priority select (bit 0 unused) |
| ack | input | 1 | CPU acknowledge of the presented request |
| reti | input | 1 | CPU return from interrupt |
| irq | output | 1 | Interrupt request to the CPU |
| vector | output | 8 | Vector address of the presented source |
| src_id | output | 4 | Number of the presented source |

## Verification
Every single source is driven alone under both priority settings, with global and individual enables on and off. This separates the gating of source 0 from the gating of the others, and it checks every vector. Every ordered pair of distinct sources is then driven under all four combinations of their priority bits. This separates a level-first choice from a number-first choice. Each source is also driven through its second flag alone, which shows which sources honour it. Directed sequences then nest all three levels and retire them one at a time. They also change requests while one is pending, and pulse acknowledge while idle. These show hold stability, strict preemption, and that return clears only the top level.

// File: rtl/intc3_pkg.sv
package intc3_pkg;
    localparam int NSRC = 16;
    localparam int IDW  = $clog2(NSRC);
    localparam int LVLS = 3;
    localparam int LW   = 2;
    localparam int VW   = 8;

    typedef enum logic [LW-1:0] {
        LV_LOW  = 2'd0,
        LV_HIGH = 2'd1,
        LV_TOP  = 2'd2
    } lvl_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } st_e;

    // Fixed vector map: source 0 sits at 33h, others step by 8 and skip 33h
    function automatic logic [VW-1:0] vec_of(input logic [IDW-1:0] id);
        logic [VW-1:0] base;
        base = {1'b0, id, 3'b000};
        if (id == '0)
            return 8'h33;
        else if (id < 4'd7)
            return base - 8'd5;
        else
            return base + 8'd3;
    endfunction
endpackage

// File: rtl/intc3_qualify.sv
module intc3_qualify #(
    parameter int              NSRC     = 16,
    parameter int              LVLS     = 3,
    parameter logic [NSRC-1:0] ALT_MASK = 16'hA004
) (
    input  logic [NSRC-1:0]            flag,
    input  logic [NSRC-1:0]            alt,
    input  logic [NSRC-1:0]            en,
    input  logic                       gen,
    input  logic [NSRC-1:0]            hi,
    output logic [LVLS-1:0][NSRC-1:0]  pend
);
    logic [NSRC-1:0] raw;
    assign raw = flag | (alt & ALT_MASK);

    // Source 0: reserved top level, own enable only
    assign pend[LVLS-1][0] = raw[0] & en[0];
    for (genvar l = 0; l < LVLS - 1; l++) begin : g_zero
        assign pend[l][0] = 1'b0;
    end

    for (genvar i = 1; i < NSRC; i++) begin : g_src
        logic q;
        assign q             = raw[i] & en[i] & gen;
        assign pend[1][i]    = q & hi[i];
        assign pend[0][i]    = q & ~hi[i];
        assign pend[LVLS-1][i] = 1'b0;
    end
endmodule

// File: rtl/intc3_pick.sv
module intc3_pick #(
    parameter int NSRC = 16,
    parameter int LVLS = 3,
    parameter int IDW  = 4,
    parameter int LW   = 2
) (
    input  logic [LVLS-1:0][NSRC-1:0] pend,
    input  logic [LVLS-1:0]           isv,
    output logic                      valid,
    output logic [IDW-1:0]            id,
    output logic [LW-1:0]             lvl
);
    logic [LVLS-1:0] lv_valid;
    logic [IDW-1:0]  lv_id [LVLS];

    for (genvar g = 0; g < LVLS; g++) begin : g_lv
        logic [IDW-1:0] idl;
        always_comb begin
            idl = '0;
            for (int i = NSRC - 1; i >= 0; i--)
                if (pend[g][i]) idl = IDW'(i);
        end
        assign lv_valid[g] = |pend[g];
        assign lv_id[g]    = idl;
    end

    always_comb begin
        int flr;
        flr   = 0;
        valid = 1'b0;
        id    = '0;
        lvl   = '0;
        for (int l = 0; l < LVLS; l++)
            if (isv[l]) flr = l + 1;
        for (int l = 0; l < LVLS; l++)
            if (lv_valid[l] && l >= flr) begin
                valid = 1'b1;
                id    = lv_id[l];
                lvl   = LW'(l);
            end
    end
endmodule

// File: rtl/intc3_ctrl.sv
module intc3_ctrl
    import intc3_pkg::*;
#(
    parameter int LVLS = 3,
    parameter int IDW  = 4,
    parameter int LW   = 2,
    parameter int VW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_valid,
    input  logic [IDW-1:0]  cand_id,
    input  logic [LW-1:0]   cand_lvl,
    input  logic            ack,
    input  logic            reti,
    output logic            irq,
    output logic [VW-1:0]   vec,
    output logic [IDW-1:0]  sid,
    output logic [LW-1:0]   lvl_q,
    output logic [LVLS-1:0] isv_q
);
    st_e             state, state_nxt;
    logic [LVLS-1:0] isv_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (cand_valid) state_nxt = ST_WAIT_ACK;
            ST_WAIT_ACK: if (ack)        state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec   <= '0;
            sid   <= '0;
            lvl_q <= '0;
        end else if (state == ST_IDLE && cand_valid) begin
            vec   <= vec_of(cand_id);
            sid   <= cand_id;
            lvl_q <= cand_lvl;
        end
    end

    assign irq = (state == ST_WAIT_ACK);

    always_comb begin
        int top;
        top     = -1;
        isv_nxt = isv_q;
        for (int l = 0; l < LVLS; l++)
            if (isv_q[l]) top = l;
        if (reti && top >= 0) isv_nxt[top] = 1'b0;
        if (state == ST_WAIT_ACK && ack) isv_nxt[lvl_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) isv_q <= '0;
        else        isv_q <= isv_nxt;
    end
endmodule

// File: rtl/intc3_top.sv
module intc3_top
    import intc3_pkg::*;
#(
    parameter logic [NSRC-1:0] ALT_MASK = 16'hA004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_flag,
    input  logic [NSRC-1:0] req_alt,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] src_hi,
    input  logic            ack,
    input  logic            reti,
    output logic            irq,
    output logic [VW-1:0]   vector,
    output logic [IDW-1:0]  src_id
);
    logic [LVLS-1:0][NSRC-1:0] pend;
    logic                      cand_valid;
    logic [IDW-1:0]            cand_id;
    logic [LW-1:0]             cand_lvl;
    logic [LW-1:0]             lvl_q;
    logic [LVLS-1:0]           isv_q;

    intc3_qualify #(.NSRC(NSRC), .LVLS(LVLS), .ALT_MASK(ALT_MASK)) u_qual (
        .flag(req_flag), .alt(req_alt), .en(src_en), .gen(glob_en),
        .hi(src_hi), .pend(pend)
    );

    intc3_pick #(.NSRC(NSRC), .LVLS(LVLS), .IDW(IDW), .LW(LW)) u_pick (
        .pend(pend), .isv(isv_q), .valid(cand_valid), .id(cand_id), .lvl(cand_lvl)
    );

    intc3_ctrl #(.LVLS(LVLS), .IDW(IDW), .LW(LW), .VW(VW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_lvl(cand_lvl), .ack(ack), .reti(reti), .irq(irq), .vec(vector),
        .sid(src_id), .lvl_q(lvl_q), .isv_q(isv_q)
    );
endmodule

// File: rtl/intc3_chk.sv
module intc3_chk
    import intc3_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            ack,
    input logic            reti,
    input logic            glob_en,
    input logic [NSRC-1:0] src_en,
    input logic [VW-1:0]   vector,
    input logic [IDW-1:0]  src_id,
    input logic [LVLS-1:0] isv,
    input logic [LW-1:0]   cur_lvl
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack |=> irq && $stable(vector) && $stable(src_id)); // R8
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq && ack |=> !irq); // R9
    AST_VEC_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> vector == vec_of(src_id)); // R6
    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !irq && !glob_en && !src_en[0] |=> !irq); // R3
    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (isv >> cur_lvl) == '0); // R10
    AST_RETI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reti && isv != '0 && !(irq && ack) |=> $countones(isv) + 1 == $countones($past(isv))); // R11
endmodule

bind intc3_top intc3_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ack(ack), .reti(reti),
    .glob_en(glob_en), .src_en(src_en), .vector(vector), .src_id(src_id),
    .isv(isv_q), .cur_lvl(lvl_q)
);

// File: tb/test_intc3_top.sv
module test_intc3_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] req_flag, req_alt, src_en, src_hi;
    logic        glob_en, ack, reti;
    logic        irq;
    logic [7:0]  vector;
    logic [3:0]  src_id;

    int nvec = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    intc3_top i_intc3_top (
        .clk(clk), .rst_n(rst_n), .req_flag(req_flag), .req_alt(req_alt),
        .src_en(src_en), .glob_en(glob_en), .src_hi(src_hi), .ack(ack),
        .reti(reti), .irq(irq), .vector(vector), .src_id(src_id)
    );

    function automatic int exp_vec(input int n);
        if (n == 0) return 51;
        return 3 + 8 * (n - 1) + ((n >= 7) ? 8 : 0);
    endfunction

    function automatic int model(input logic [15:0] f, a, e, input logic g, input logic [15:0] p);
        logic [15:0] r;
        int best, blv;
        r = f | (a & 16'hA004);
        best = -1; blv = -1;
        for (int i = 0; i < 16; i++) begin
            logic q;
            int lv;
            q  = (i == 0) ? (r[0] & e[0]) : (r[i] & e[i] & g);
            lv = (i == 0) ? 2 : int'(p[i]);
            if (q && lv > blv) begin best = i; blv = lv; end
        end
        return best;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    task automatic run_vec(input logic [15:0] f, a, e, input logic g,
                           input logic [15:0] p, input string tag);
        int w;
        w = model(f, a, e, g, p);
        req_flag = f; req_alt = a; src_en = e; glob_en = g; src_hi = p;
        tick();
        chk(int'(irq), (w >= 0) ? 1 : 0, {tag, " irq"});
        if (w >= 0) begin
            chk(int'(src_id), w, {tag, " id"});
            chk(int'(vector), exp_vec(w), {tag, " R6 vector"});
            pulse_ack();
            req_flag = '0; req_alt = '0;
            chk(int'(irq), 0, "R9 drop after ack");
            pulse_reti();
        end
        req_flag = '0; req_alt = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_flag = '1; req_alt = '1; src_en = '1; glob_en = 1'b1;
        src_hi = '0; ack = 1'b0; reti = 1'b0;
        repeat (3) tick();
        chk(int'(irq), 0, "R1 irq in reset");
        chk(int'(vector), 0, "R1 vector in reset");
        chk(int'(src_id), 0, "R1 id in reset");
        req_flag = '0; req_alt = '0;
        rst_n = 1'b1;
        tick();
        chk(int'(irq), 0, "R1 idle after reset");

        // Single sources: R2, R3, R4, R6
        for (int i = 0; i < 16; i++)
            for (int c = 0; c < 8; c++) begin
                logic [15:0] bit_i;
                bit_i = 16'(1 << i);
                run_vec(bit_i, '0, c[0] ? 16'hFFFF : ~bit_i, c[1],
                        c[2] ? 16'hFFFF : 16'h0000,
                        (i == 0) ? "R2 single" : "R3 single");
            end

        // Pairs: R4 level first, R5 number order
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                if (i != j)
                    for (int pc = 0; pc < 4; pc++) begin
                        logic [15:0] pr;
                        pr = (pc[0] ? 16'(1 << i) : 16'h0) | (pc[1] ? 16'(1 << j) : 16'h0);
                        run_vec(16'(1 << i) | 16'(1 << j), '0, '1, 1'b1, pr,
                                (pc == 0 || pc == 3) ? "R5 pair" : "R4 pair");
                    end

        // Second flags: R7
        for (int i = 0; i < 16; i++)
            run_vec('0, 16'(1 << i), '1, 1'b1, '0, "R7 alt");

        // Hold while pending, then strict preemption: R8, R10
        src_en = '1; glob_en = 1'b1; src_hi = '0;
        req_flag = 16'h0200;
        tick();
        chk(int'(src_id), 9, "R8 first winner");
        req_flag = 16'h0001;
        repeat (3) tick();
        chk(int'(irq), 1, "R8 irq held");
        chk(int'(src_id), 9, "R8 id held");
        chk(int'(vector), 8'h4B, "R8 vector held");
        pulse_ack();
        chk(int'(irq), 0, "R9 irq falls");
        tick();
        chk(int'(src_id) + 16 * int'(irq), 16, "R10 top preempts low");
        pulse_ack();
        req_flag = '0;
        pulse_reti(); pulse_reti();
        tick();
        chk(int'(irq), 0, "R11 cleared all");

        // Ack while idle has no effect: R9
        pulse_ack();
        req_flag = 16'h0010;
        tick();
        chk(int'(irq), 1, "R9 ack in idle ignored");
        chk(int'(src_id), 4, "R9 id after idle ack");
        pulse_ack(); req_flag = '0; pulse_reti();

        // Nesting: R10, R11
        req_flag = 16'h0020; tick();
        chk(int'(src_id), 5, "R10 low served");
        pulse_ack();
        req_flag = 16'h0008; tick(); tick();
        chk(int'(irq), 0, "R10 same level waits");
        src_hi = 16'h0080; req_flag = 16'h0088; tick();
        chk(int'(src_id), 7, "R10 high preempts low");
        pulse_ack();
        req_flag = 16'h0009; tick();
        chk(int'(src_id), 0, "R10 top preempts high");
        pulse_ack();
        req_flag = 16'h0009;
        pulse_reti();
        tick();
        chk(int'(src_id) + 16 * int'(irq), 16, "R11 top freed by reti");
        pulse_ack();
        req_flag = 16'h0008;
        pulse_reti(); pulse_reti();
        tick();
        chk(int'(irq), 0, "R11 low still in service");
        pulse_reti();
        tick();
        chk(int'(src_id) + 16 * int'(irq), 19, "R11 low freed last");
        pulse_ack(); req_flag = '0; pulse_reti();
        pulse_reti();
        tick();
        chk(int'(irq), 0, "R11 reti when empty");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule